// File: doc/BRIEF.md
# Synchronous Setpoint Ramp Sequencer

This block drives the current setpoint of one power-supply channel. It either passes on a single setpoint written directly, or it plays back a stored table of setpoints, one entry per update tick. The update tick is derived from the system clock by a divider, and its default ratio gives one tick every 100 µs (10 kHz) from a 250 MHz clock. A host fills the table through a plain address, data and write-enable port. It sets the index of the final entry through a length write, then arms the block.

Table playback starts only when an armed block sees the shared trigger pulse. The trigger also restarts the tick divider. As a result, every controller in a group that was armed before the same trigger emits entry k on the same clock. The result is a setpoint word with a one-cycle valid strobe for each emitted value, plus a two-bit state code. With a table depth of 10,000 entries, a full ramp lasts one second. The default depth is kept smaller so that the default build stays compact. Depth, word width and tick ratio are all parameters.

Top module: `ramp_seq`

## Requirements
- R1: While reset is applied and after its release, `state` reads 0 (idle), `sp_out` reads 0 and `sp_valid` is low.
- R2: A table write stores `tbl_data` at `tbl_addr`. Playback emits the stored entries in rising index order, from index 0 up to and including the programmed last index, up to index DEPTH-1.
- R3: The `state` port codes are idle = 0, armed = 1, running = 2 and done = 3. A pulse on `arm` in idle or done moves the block to armed. A pulse on `trig` in armed moves it to running on the next clock.
- R4: A `trig` pulse in idle, running or done changes neither the state nor the output, and produces no strobe.
- R5: The first table value is strobed exactly TICK_DIV clocks after the clock edge that samples `trig`. Each later entry follows exactly TICK_DIV clocks after the previous one, and `sp_valid` is high for one clock per value.
- R6: A direct write (`dir_we`) in idle or done produces exactly one strobe carrying `dir_data`, between 1 and TICK_DIV clocks after the sampling edge. A direct write in armed or running is dropped.
- R7: After the last index is emitted, the block enters done. `sp_out` keeps that final value and no further table strobes occur.
- R8: `abort` returns the block to idle on the next clock from any state. `sp_out` holds its value, no strobe follows, and any direct write still waiting is discarded.
- R9: A length write (`len_we`) sets the last index only when the block is not running and `len_last` is below DEPTH. Otherwise the previous last index is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | AW | Table write address, AW = clog2(DEPTH) |
| tbl_data | input | SPW | Table write data |
| len_we | input | 1 | Last-index write enable |
| len_last | input | AW | Index of the final table entry |
| arm | input | 1 | Arm request pulse |
| trig | input | 1 | Shared group trigger pulse |
| abort | input | 1 | Abort pulse, back to idle |
| dir_we | input | 1 | Direct setpoint write enable |
| dir_data | input | SPW | Direct setpoint value |
| sp_out | output | SPW | Setpoint word to the converter |
| sp_valid | output | 1 | One-clock strobe marking a new setpoint |
| state | output | 2 | Sequencer state code |

## Verification
Table values have a fixed timing. Entry k appears exactly (k+1)·TICK_DIV clocks after the edge that samples the trigger. Because the tick runs freely while the block is idle or done, a direct setpoint may land anywhere from 1 to TICK_DIV clocks after its write. The driver therefore pushes every expected value into the scoreboard along with a window of allowed clock numbers. For table entries the window is a single clock; for direct writes it is the full range. The monitor samples on the falling edge, counts rising edges, and rejects any strobe that has no queued entry, carries the wrong value or falls outside its window. State and held-output checks are taken only after the edge that registers the stimulus.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_RUN   = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/ramp_tick_gen.sv
module ramp_tick_gen #(
  parameter int DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);

  initial begin
    a_r5_div_min: assert (DIV >= 2);
  end

  // R5: a tick never lasts more than one clock
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ramp_table.sv
module ramp_table #(
  parameter int DEPTH = 4096,
  parameter int SPW   = 20,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [SPW-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [SPW-1:0] rdata
);

  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [SPW-1:0] mem [DEPTH];
  logic [SPW-1:0] rdata_q;
  logic           wr_ok;

  assign wr_ok = we && ({1'b0, waddr} < DEPTH_W);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_seq_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int SPW   = 20,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           len_we,
  input  logic [AW-1:0]  len_last,
  input  logic           arm,
  input  logic           trig,
  input  logic           abort,
  input  logic           dir_we,
  input  logic [SPW-1:0] dir_data,
  input  logic [SPW-1:0] rd_data,
  output logic [AW-1:0]  rd_addr,
  output logic           restart,
  output logic [SPW-1:0] sp_out,
  output logic           sp_valid,
  output logic [1:0]     state
);

  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  seq_state_e     st_q, st_d;
  logic [AW-1:0]  idx_q, idx_d;
  logic [AW-1:0]  last_q, last_d;
  logic           pend_q, pend_d;
  logic [SPW-1:0] pval_q, pval_d;
  logic [SPW-1:0] out_q, out_d;
  logic           vld_q, vld_d;
  logic           quiet;

  assign quiet = (st_q == SQ_IDLE) || (st_q == SQ_DONE);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    last_d  = last_q;
    pend_d  = pend_q;
    pval_d  = pval_q;
    out_d   = out_q;
    vld_d   = 1'b0;
    restart = 1'b0;

    if (len_we && (st_q != SQ_RUN) && ({1'b0, len_last} < DEPTH_W))
      last_d = len_last;

    // queued direct value leaves on the tick
    if (tick && pend_q && (st_q != SQ_RUN)) begin
      out_d  = pval_q;
      vld_d  = 1'b1;
      pend_d = 1'b0;
    end

    if (dir_we && quiet) begin
      pend_d = 1'b1;
      pval_d = dir_data;
    end

    unique case (st_q)
      SQ_IDLE, SQ_DONE: begin
        if (arm) st_d = SQ_ARMED;
      end
      SQ_ARMED: begin
        if (trig) begin
          st_d    = SQ_RUN;
          idx_d   = '0;
          restart = 1'b1;
          pend_d  = 1'b0;
        end
      end
      SQ_RUN: begin
        if (tick) begin
          out_d = rd_data;
          vld_d = 1'b1;
          if (idx_q == last_q) st_d  = SQ_DONE;
          else                 idx_d = idx_q + AW'(1);
        end
      end
      default: st_d = SQ_IDLE;
    endcase

    if (abort) begin
      st_d    = SQ_IDLE;
      idx_d   = idx_q;
      pend_d  = 1'b0;
      out_d   = out_q;
      vld_d   = 1'b0;
      restart = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      pend_q <= 1'b0;
      pval_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      pend_q <= pend_d;
      pval_q <= pval_d;
      out_q  <= out_d;
      vld_q  <= vld_d;
    end
  end

  assign rd_addr  = idx_q;
  assign sp_out   = out_q;
  assign sp_valid = vld_q;
  assign state    = st_q;

  // R8: abort lands in idle with the output frozen
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st_q == SQ_IDLE) && !vld_q);
  a_r8_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> $stable(out_q));

  // R4: running is entered only from armed with a trigger
  a_r4_run_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN && $past(st_q) != SQ_RUN) |-> ($past(st_q) == SQ_ARMED && $past(trig)));

  // R5: every strobe follows a divider tick
  a_r5_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(tick));

  // R6: no direct value waits while a ramp plays
  a_r6_no_pend_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN) |-> !pend_q);

  // R7: a ramp that stops without abort ends in done
  a_r7_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == SQ_RUN && st_q != SQ_RUN && !$past(abort)) |-> (st_q == SQ_DONE));

  // R9: last index stays inside the table
  a_r9_last_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, last_q} < DEPTH_W);

endmodule

// File: rtl/ramp_seq.sv
module ramp_seq #(
  parameter int SPW      = 20,
  parameter int DEPTH    = 4096,
  parameter int TICK_DIV = 25000,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tbl_we,
  input  logic [AW-1:0]  tbl_addr,
  input  logic [SPW-1:0] tbl_data,
  input  logic           len_we,
  input  logic [AW-1:0]  len_last,
  input  logic           arm,
  input  logic           trig,
  input  logic           abort,
  input  logic           dir_we,
  input  logic [SPW-1:0] dir_data,
  output logic [SPW-1:0] sp_out,
  output logic           sp_valid,
  output logic [1:0]     state
);

  logic [1:0]     rs_q;
  logic           rst_ni;
  logic           tick;
  logic           restart;
  logic [AW-1:0]  rd_addr;
  logic [SPW-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  ramp_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk     (clk),
    .rst_n   (rst_ni),
    .restart (restart),
    .tick    (tick)
  );

  ramp_table #(.DEPTH(DEPTH), .SPW(SPW)) i_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  ramp_ctrl #(.DEPTH(DEPTH), .SPW(SPW)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .tick     (tick),
    .len_we   (len_we),
    .len_last (len_last),
    .arm      (arm),
    .trig     (trig),
    .abort    (abort),
    .dir_we   (dir_we),
    .dir_data (dir_data),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .restart  (restart),
    .sp_out   (sp_out),
    .sp_valid (sp_valid),
    .state    (state)
  );

endmodule

// File: tb/test_ramp_seq.sv
module test_ramp_seq;

  localparam int SPW   = 20;
  localparam int DEPTH = 48;
  localparam int DIV   = 8;
  localparam int AW    = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tbl_we, len_we, arm, trig, abort, dir_we;
  logic [AW-1:0]  tbl_addr, len_last;
  logic [SPW-1:0] tbl_data, dir_data;
  logic [SPW-1:0] sp_out;
  logic           sp_valid;
  logic [1:0]     state;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit live  = 0;
  bit fin   = 0;
  string cur_req = "R1";

  logic [SPW-1:0] exp_v[$];
  int             exp_lo[$];
  int             exp_hi[$];

  ramp_seq #(.SPW(SPW), .DEPTH(DEPTH), .TICK_DIV(DIV)) i_ramp_seq (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .len_we(len_we), .len_last(len_last), .arm(arm),
    .trig(trig), .abort(abort), .dir_we(dir_we), .dir_data(dir_data),
    .sp_out(sp_out), .sp_valid(sp_valid), .state(state)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [SPW-1:0] tv(int i);
    return SPW'(i * 4660 + 2748);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare each strobe
  always @(negedge clk) begin
    if (live && sp_valid) begin
      if (exp_v.size() == 0) begin
        chk(0, cur_req, "unexpected strobe", sp_out, 0);
      end else begin
        logic [SPW-1:0] v;
        int lo, hi;
        v = exp_v.pop_front(); lo = exp_lo.pop_front(); hi = exp_hi.pop_front();
        chk(sp_out == v, cur_req, "strobe value", sp_out, v);
        chk(cyc >= lo && cyc <= hi, cur_req, "strobe clock", cyc, lo);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tbl(int a, logic [SPW-1:0] d);
    @(negedge clk); tbl_we = 1; tbl_addr = AW'(a); tbl_data = d;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic wr_len(int l);
    @(negedge clk); len_we = 1; len_last = AW'(l);
    @(negedge clk); len_we = 0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic do_trig(output int t0);
    @(negedge clk); trig = 1; t0 = cyc + 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic direct(logic [SPW-1:0] d, bit expect_it);
    int w;
    @(negedge clk); dir_we = 1; dir_data = d; w = cyc + 1;
    if (expect_it) begin
      exp_v.push_back(d); exp_lo.push_back(w + 1); exp_hi.push_back(w + DIV);
    end
    @(negedge clk); dir_we = 0;
  endtask

  task automatic push_run(int t0, int n);
    for (int k = 0; k < n; k++) begin
      exp_v.push_back(tv(k));
      exp_lo.push_back(t0 + (k + 1) * DIV);
      exp_hi.push_back(t0 + (k + 1) * DIV);
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_v.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    chk(exp_v.size() == 0, cur_req, "scoreboard drained", exp_v.size(), 0);
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0;
    rst_n = 0; tbl_we = 0; len_we = 0; arm = 0; trig = 0; abort = 0; dir_we = 0;
    tbl_addr = '0; tbl_data = '0; len_last = '0; dir_data = '0;
    idle(4);
    // R1 during reset
    chk(state == 2'd0, "R1", "state in reset", state, 0);
    chk(sp_out == '0 && !sp_valid, "R1", "output in reset", sp_out, 0);
    @(negedge clk); rst_n = 1;
    idle(4);
    live = 1;
    chk(state == 2'd0 && sp_out == '0 && !sp_valid, "R1", "after reset", sp_out, 0);

    // R2 table load
    for (int i = 0; i < DEPTH; i++) wr_tbl(i, tv(i));
    wr_len(4);

    // R6 direct write in idle
    cur_req = "R6";
    direct(20'h12345, 1);
    drain();
    chk(sp_out == 20'h12345, "R6", "direct value held", sp_out, 20'h12345);

    // R4 trigger in idle ignored
    cur_req = "R4";
    do_trig(t0);
    idle(3 * DIV);
    chk(state == 2'd0, "R4", "trig in idle", state, 0);

    // R3 arm; R6 direct in armed dropped
    do_arm();
    chk(state == 2'd1, "R3", "armed code", state, 1);
    cur_req = "R6";
    direct(20'h0F0F0, 0);
    idle(2 * DIV);
    chk(state == 2'd1 && sp_out == 20'h12345, "R6", "direct in armed dropped", sp_out, 20'h12345);

    // R5 timed playback of entries 0..4
    cur_req = "R5";
    do_trig(t0);
    push_run(t0, 5);
    chk(state == 2'd2, "R3", "running code", state, 2);
    cur_req = "R4";
    do_trig(t0);
    chk(state == 2'd2, "R4", "trig in running", state, 2);
    cur_req = "R5";
    drain();
    chk(state == 2'd3, "R7", "done code", state, 3);
    chk(sp_out == tv(4), "R7", "final value held", sp_out, tv(4));
    cur_req = "R7";
    idle(3 * DIV);
    chk(sp_out == tv(4), "R7", "final value after wait", sp_out, tv(4));

    // R4 trigger in done ignored
    cur_req = "R4";
    do_trig(t0);
    idle(3 * DIV);
    chk(state == 2'd3, "R4", "trig in done", state, 3);

    // R6 direct in done accepted
    cur_req = "R6";
    direct(20'hABCDE, 1);
    drain();
    chk(sp_out == 20'hABCDE, "R6", "direct in done", sp_out, 20'hABCDE);

    // R9 out-of-range length and length written while running are ignored
    cur_req = "R9";
    wr_len(2);
    wr_len(50);
    do_arm();
    do_trig(t0);
    push_run(t0, 3);
    wr_len(10);
    drain();
    chk(state == 2'd3 && sp_out == tv(2), "R9", "three entries played", sp_out, tv(2));

    // R7 single-entry ramp
    cur_req = "R7";
    wr_len(0);
    do_arm();
    do_trig(t0);
    push_run(t0, 1);
    drain();
    chk(state == 2'd3 && sp_out == tv(0), "R7", "one-entry ramp", sp_out, tv(0));

    // R2 full table up to the last index
    cur_req = "R2";
    wr_len(DEPTH - 1);
    do_arm();
    do_trig(t0);
    push_run(t0, DEPTH);
    drain();
    chk(sp_out == tv(DEPTH - 1), "R2", "last table index", sp_out, tv(DEPTH - 1));

    // R8 abort during running
    cur_req = "R8";
    do_arm();
    do_trig(t0);
    push_run(t0, 2);
    while (cyc < t0 + 2 * DIV + 1) @(negedge clk);
    abort = 1;
    @(negedge clk); abort = 0;
    chk(state == 2'd0, "R8", "abort to idle", state, 0);
    chk(sp_out == tv(1), "R8", "abort holds output", sp_out, tv(1));
    idle(4 * DIV);
    chk(exp_v.size() == 0 && sp_out == tv(1), "R8", "no strobe after abort", sp_out, tv(1));

    // R8 abort discards a waiting direct value
    direct(20'h55555, 0);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    idle(2 * DIV);
    chk(sp_out == tv(1), "R8", "pending direct dropped", sp_out, tv(1));

    // R8 abort from armed
    do_arm();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    chk(state == 2'd0, "R8", "abort from armed", state, 0);

    idle(4);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule